// File: doc/BRIEF.md
# Dual-Channel Byte-Loaded Double-Buffered Register Controller

This block is the digital front end of a two-channel 12-bit converter fed from an 8-bit bus. Each channel holds a staging pair (an 8-bit low register and a 4-bit high register) and a 12-bit output word. A byte write goes to one staging register of one channel. The channel is picked by `ch_sel` and the register by `hi_sel`, so a word can be assembled from its two bytes in either order.

A separate load strobe `ld_n` copies the staging contents of both channels into both output words on the same clock edge, so the two outputs always change together. The strobe can be given in the same cycle as the final byte write. In that case the byte being written goes straight into the output word along with the byte already staged, and an update of both channels takes four write cycles. The strobe can also be given on its own after four plain writes, which makes a five-cycle update. All logic runs on one clock. Reset is synchronous and active high, and it overrides writes and loads.

Top module: `dual_byte_loader`

## Requirements
- R1: A write cycle (`wr_n` = 0) with `hi_sel` = 0 stores all 8 bits of `din` in the low staging register of the addressed channel. `ch_sel` = 0 addresses channel A and `ch_sel` = 1 addresses channel B.
- R2: A write cycle with `hi_sel` = 1 stores `din[3:0]` in the high staging register of the addressed channel. `din[7:4]` has no effect.
- R3: A write changes only the one staging register it addresses. The other staging register of that channel and both staging registers of the other channel keep their values.
- R4: A channel's 12-bit word is `{high[3:0], low[7:0]}`, and its two halves can be written in either order with the same result.
- R5: On an edge where `ld_n` = 0, both output words take their channel's staging contents together, whether or not a write happens in that cycle.
- R6: When `ld_n` = 0 and `wr_n` = 0 in the same cycle, the byte being written is also forwarded into the addressed channel's output word on that same edge.
- R7: While `ld_n` = 1, neither output word changes, even when byte writes are happening.
- R8: On an edge where `rst` = 1, all six registers become zero, whatever `wr_n` and `ld_n` are doing. A word loaded after reset holds zero in any half that has not been written since.
- R9: With `wr_n` = 1 and `ld_n` = 1, every register keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all registers update on its rising edge |
| rst | input | 1 | Synchronous active-high clear of all registers |
| wr_n | input | 1 | Active-low byte write strobe |
| ld_n | input | 1 | Active-low load strobe for both output words |
| ch_sel | input | 1 | Target channel of a write: 0 = A, 1 = B |
| hi_sel | input | 1 | Target half of a write: 0 = low byte, 1 = high nibble |
| din | input | 8 | Write data bus |
| out_a | output | 12 | Registered output word of channel A |
| out_b | output | 12 | Registered output word of channel B |

## Verification
The staging registers can only be seen through a load, so a bad staging register shows at the ports at the first load that copies it. In automatic mode that load falls on the same cycle as the write. In strobed mode it falls on the later strobe cycle, up to four writes afterwards. A bad output register or a bad load decode shows one edge after the cycle that caused it, either as an output that changed while `ld_n` was high or as two channels that did not update together. The sweeps therefore compare both outputs against an arithmetic model after every single cycle, so any divergence is reported in the cycle where it first reaches a port.

// File: rtl/dbl_pkg.sv
package dbl_pkg;
  localparam int NCH = 2;

  typedef enum logic {
    PART_LO = 1'b0,
    PART_HI = 1'b1
  } part_e;

  typedef struct packed {
    logic we_lo;
    logic we_hi;
  } chan_we_t;
endpackage

// File: rtl/strobe_decode.sv
module strobe_decode
  import dbl_pkg::*;
#(
  parameter int NUM_CH = NCH,
  parameter int SEL_W  = 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_n,
  input  logic [SEL_W-1:0]    ch_sel,
  input  logic                hi_sel,
  output chan_we_t            we [NUM_CH]
);
  part_e part;
  assign part = part_e'(hi_sel);

  logic [2*NUM_CH-1:0] we_flat;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic hit;
    assign hit       = !wr_n && (ch_sel == SEL_W'(c));
    assign we[c].we_lo = hit && (part == PART_LO);
    assign we[c].we_hi = hit && (part == PART_HI);
    assign we_flat[2*c]   = we[c].we_lo;
    assign we_flat[2*c+1] = we[c].we_hi;
  end

  // A single write never reaches more than one staging register (R3)
  assert_single_target_R3: assert property (@(posedge clk) disable iff (rst)
    $onehot0(we_flat));

  // An idle write strobe enables nothing (R9)
  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    wr_n |-> (we_flat == '0));
endmodule

// File: rtl/input_stage.sv
module input_stage #(
  parameter int BUS_W  = 8,
  parameter int WORD_W = 12,
  localparam int HI_W  = WORD_W - BUS_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we_lo,
  input  logic              we_hi,
  input  logic [BUS_W-1:0]  din,
  output logic [BUS_W-1:0]  lo_nxt,
  output logic [HI_W-1:0]   hi_nxt,
  output logic [BUS_W-1:0]  lo_q,
  output logic [HI_W-1:0]   hi_q
);
  always_comb begin
    lo_nxt = we_lo ? din : lo_q;
    hi_nxt = we_hi ? din[HI_W-1:0] : hi_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      lo_q <= lo_nxt;
      hi_q <= hi_nxt;
    end
  end

  // Staging registers move only when addressed (R3, R9)
  assert_lo_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !we_lo |=> $stable(lo_q));
  assert_hi_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !we_hi |=> $stable(hi_q));

  // High write takes only the low nibble of the bus (R2)
  assert_hi_nibble_R2: assert property (@(posedge clk) disable iff (rst)
    we_hi |=> (hi_q == $past(din[HI_W-1:0])));

  // Reset clears both staging registers (R8)
  logic rst_seen;
  always_ff @(posedge clk) rst_seen <= rst;
  always_comb begin
    if (rst_seen) begin
      assert_stage_clear_R8: assert ((lo_q == '0) && (hi_q == '0));
    end
  end
endmodule

// File: rtl/output_stage.sv
module output_stage #(
  parameter int WORD_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_n,
  input  logic [WORD_W-1:0] word_nxt,
  output logic [WORD_W-1:0] word_q
);
  always_ff @(posedge clk) begin
    if (rst)        word_q <= '0;
    else if (!ld_n) word_q <= word_nxt;
  end

  // Output word stays put while the load strobe is high (R7)
  assert_out_hold_R7: assert property (@(posedge clk) disable iff (rst)
    ld_n |=> $stable(word_q));

  // Load takes the staging contents including a same-cycle write (R5, R6)
  assert_out_load_R6: assert property (@(posedge clk) disable iff (rst)
    !ld_n |=> (word_q == $past(word_nxt)));

  logic rst_seen;
  always_ff @(posedge clk) rst_seen <= rst;
  always_comb begin
    if (rst_seen) begin
      assert_out_clear_R8: assert (word_q == '0);
    end
  end
endmodule

// File: rtl/dual_byte_loader.sv
module dual_byte_loader
  import dbl_pkg::*;
#(
  parameter int BUS_W  = 8,
  parameter int WORD_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_n,
  input  logic              ld_n,
  input  logic              ch_sel,
  input  logic              hi_sel,
  input  logic [BUS_W-1:0]  din,
  output logic [WORD_W-1:0] out_a,
  output logic [WORD_W-1:0] out_b
);
  localparam int HI_W = WORD_W - BUS_W;

  chan_we_t          we     [NCH];
  logic [WORD_W-1:0] word_q [NCH];

  strobe_decode #(.NUM_CH(NCH), .SEL_W(1)) u_dec (
    .clk    (clk),
    .rst    (rst),
    .wr_n   (wr_n),
    .ch_sel (ch_sel),
    .hi_sel (hi_sel),
    .we     (we)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    logic [BUS_W-1:0] lo_nxt, lo_q;
    logic [HI_W-1:0]  hi_nxt, hi_q;

    input_stage #(.BUS_W(BUS_W), .WORD_W(WORD_W)) u_in (
      .clk    (clk),
      .rst    (rst),
      .we_lo  (we[c].we_lo),
      .we_hi  (we[c].we_hi),
      .din    (din),
      .lo_nxt (lo_nxt),
      .hi_nxt (hi_nxt),
      .lo_q   (lo_q),
      .hi_q   (hi_q)
    );

    output_stage #(.WORD_W(WORD_W)) u_out (
      .clk      (clk),
      .rst      (rst),
      .ld_n     (ld_n),
      .word_nxt ({hi_nxt, lo_nxt}),
      .word_q   (word_q[c])
    );
  end

  assign out_a = word_q[0];
  assign out_b = word_q[1];

  // Both outputs change only on load edges, never one without the strobe (R5)
  assert_joint_update_R5: assert property (@(posedge clk) disable iff (rst)
    ld_n |=> ($stable(out_a) && $stable(out_b)));
endmodule

// File: tb/test_dual_byte_loader.sv
module test_dual_byte_loader;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_n = 1'b1;
  logic        ld_n = 1'b1;
  logic        ch_sel = 1'b0;
  logic        hi_sel = 1'b0;
  logic [7:0]  din = '0;
  logic [11:0] out_a, out_b;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [7:0]  m_lo  [2];
  logic [3:0]  m_hi  [2];
  logic [11:0] m_out [2];

  always #5 clk = ~clk;

  dual_byte_loader i_dual_byte_loader (
    .clk(clk), .rst(rst), .wr_n(wr_n), .ld_n(ld_n),
    .ch_sel(ch_sel), .hi_sel(hi_sel), .din(din),
    .out_a(out_a), .out_b(out_b)
  );

  task automatic compare(input string tag);
    checks++;
    if (out_a !== m_out[0]) begin
      fails++;
      $display("FAIL %s out_a actual %h expected %h", tag, out_a, m_out[0]);
    end
    checks++;
    if (out_b !== m_out[1]) begin
      fails++;
      $display("FAIL %s out_b actual %h expected %h", tag, out_b, m_out[1]);
    end
  endtask

  // Drive one cycle, update the model at the edge, compare after it
  task automatic step(input string tag, input logic r, input logic w,
                      input logic l, input logic c, input logic h,
                      input logic [7:0] d);
    rst = r; wr_n = w; ld_n = l; ch_sel = c; hi_sel = h; din = d;
    @(posedge clk);
    if (r) begin
      for (int i = 0; i < 2; i++) begin
        m_lo[i] = '0; m_hi[i] = '0; m_out[i] = '0;
      end
    end else begin
      if (!w) begin
        if (h) m_hi[c] = d[3:0];
        else   m_lo[c] = d;
      end
      if (!l) begin
        for (int i = 0; i < 2; i++) m_out[i] = {m_hi[i], m_lo[i]};
      end
    end
    @(negedge clk);
    compare(tag);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 2; i++) begin
      m_lo[i] = '0; m_hi[i] = '0; m_out[i] = '0;
    end
    @(negedge clk);
    // R8: reset state
    step("R8 reset", 1, 1, 1, 0, 0, 8'h00);
    step("R8 reset with strobes", 1, 0, 0, 1, 1, 8'hFF);
    step("R9 idle after reset", 0, 1, 1, 0, 0, 8'hA5);

    // R6/R4/R1: automatic transfer, both orders, both channels
    for (int v = 0; v < 4096; v += 37) begin
      for (int c = 0; c < 2; c++) begin
        logic [11:0] word = 12'(v + c * 1111);
        if (((v / 37) % 2) == 0) begin
          step("R1 low first", 0, 0, 1, c[0], 0, word[7:0]);
          step("R6 auto high", 0, 0, 0, c[0], 1, {4'hF, word[11:8]});
        end else begin
          step("R4 high first", 0, 0, 1, c[0], 1, {4'h0, word[11:8]});
          step("R6 auto low", 0, 0, 0, c[0], 0, word[7:0]);
        end
      end
    end

    // R7/R5: strobed transfer of both channels, then a lone load
    for (int v = 5; v < 4096; v += 211) begin
      logic [11:0] wa = 12'(v);
      logic [11:0] wb = 12'(4095 - v);
      step("R7 strobed A lo", 0, 0, 1, 0, 0, wa[7:0]);
      step("R7 strobed B hi", 0, 0, 1, 1, 1, {4'hC, wb[11:8]});
      step("R7 strobed A hi", 0, 0, 1, 0, 1, {4'h3, wa[11:8]});
      step("R7 strobed B lo", 0, 0, 1, 1, 0, wb[7:0]);
      step("R9 idle hold", 0, 1, 1, 0, 0, 8'h5A);
      step("R5 lone load", 0, 1, 0, 1, 1, 8'hFF);
    end

    // R2: upper nibble of bus ignored on high write
    for (int u = 0; u < 16; u++) begin
      step("R2 hi nibble", 0, 0, 0, u[0], 1, {u[3:0], 4'h9});
    end

    // R3: writing one channel leaves the other intact across loads
    step("R3 load A", 0, 0, 0, 0, 0, 8'h11);
    step("R3 load A hi", 0, 0, 0, 0, 1, 8'h07);
    step("R3 write B only", 0, 0, 1, 1, 0, 8'hEE);
    step("R3 reload", 0, 1, 0, 0, 0, 8'h00);

    // R8: reset in the middle of a word, then finish it
    step("R8 mid lo", 0, 0, 1, 1, 0, 8'h3C);
    step("R8 mid reset", 1, 0, 0, 1, 1, 8'h0F);
    step("R8 after reset", 0, 0, 0, 1, 1, 8'h0A);
    step("R8 other channel", 0, 1, 0, 0, 0, 8'h00);

    // R9: long idle
    for (int k = 0; k < 8; k++) step("R9 idle", 0, 1, 1, k[0], k[1], 8'(k * 29));

    finish_run();
  end
endmodule